// File: doc/BRIEF.md
# Stream Frame Pixel and Line Counter

This block sits beside a video-style AXI4-Stream link and only listens to it. Every completed transfer (valid and ready both high in the same cycle) moves a pair of position counters. One gives the pixel position within the current line. The other gives the line index within the current frame. The start-of-frame marker (`tuser`) and the end-of-line marker (`tlast`) are read as levels on the accepted beat, in the same clock domain as the stream. The block never drives ready and never touches the data.

Both counters are registers and change at the clock edge that accepts a beat. The beat that carries the frame marker takes effect at that same edge. A marked beat needs no extra settling cycle. An optional one-cycle strobe reports that the beat just accepted was the first pixel of a line.

Top module: `stream_pos_counter`

## Requirements
- R1: A synchronous reset, sampled high on a rising edge, leaves the pixel count, the line count and the line-start strobe at 0 after that edge, whatever the stream inputs do.
- R2: In a cycle without a handshake (`tvalid` and `tready` not both 1), neither counter changes and the line-start strobe is 0 after the next edge.
- R3: A handshake beat with `tuser`=1 sets the pixel count to 1 and the line count to 0, both visible right after the edge that accepts the beat.
- R4: A handshake beat with `tlast`=1 and `tuser`=0 sets the pixel count to 0 and raises the line count by one.
- R5: A handshake beat with both markers 0 raises the pixel count by one.
- R6: When `tuser` and `tlast` are both 1 on one beat, the start-of-frame action (R3) applies and the end-of-line action does not.
- R7: The pixel count stops at 2^PIX_W-1. A plain beat at that value leaves it unchanged.
- R8: The line count stops at 2^LINE_W-1. An end-of-line beat at that value leaves it unchanged, though the pixel count still clears to 0.
- R9: With LSTART_EN=1, the line-start strobe is 1 for exactly the cycle after a handshake beat that has `tuser`=1 or that arrives while the pixel count is 0. After any other cycle it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared with the stream |
| rst | input | 1 | Synchronous active-high reset |
| tvalid | input | 1 | Stream valid, observed only |
| tready | input | 1 | Stream ready, observed only |
| tuser | input | 1 | Start-of-frame marker, read as a level on the beat |
| tlast | input | 1 | End-of-line marker |
| pixCount | output | PIX_W | Registered pixel position within the line |
| lineCount | output | LINE_W | Registered line index within the frame |
| lineStart | output | 1 | One-cycle strobe after the first beat of a line |

## Verification
Each output is one register stage behind the beat that moves it. The effect of inputs present before a rising edge can therefore be seen right after that edge, and nothing needs a second cycle. The bench changes inputs on the falling edge and advances its own model at the rising edge. It compares all three outputs on the following falling edge, so every check falls in the single cycle where the result is due. The model's previous state is compared again when a hold is expected.

// File: rtl/stream_pos_pkg.sv
package stream_pos_pkg;

  // Strobes passed from the beat decoder to the counter datapath
  typedef struct packed {
    logic frameStart;  // accepted beat carrying start-of-frame
    logic lineEnd;     // accepted beat closing a line (no frame marker)
    logic pixStep;     // accepted beat with neither marker
    logic lineFirst;   // accepted beat that is the first pixel of a line
  } posCtl_t;

endpackage

// File: rtl/stream_pos_ctrl.sv
module stream_pos_ctrl
  import stream_pos_pkg::*;
(
  input  logic    tvalid,
  input  logic    tready,
  input  logic    tuser,
  input  logic    tlast,
  input  logic    pixAtZero,
  output posCtl_t ctl
);

  logic beat;

  always_comb begin
    beat          = tvalid & tready;
    ctl.frameStart = beat & tuser;
    ctl.lineEnd    = beat & tlast & ~tuser;
    ctl.pixStep    = beat & ~tuser & ~tlast;
    ctl.lineFirst  = beat & (tuser | pixAtZero);
  end

endmodule

// File: rtl/stream_pos_dpath.sv
module stream_pos_dpath
  import stream_pos_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int LINE_W    = 6,
  parameter bit LSTART_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  posCtl_t           ctl,
  output logic [PIX_W-1:0]  pixCount,
  output logic [LINE_W-1:0] lineCount,
  output logic              pixAtZero,
  output logic              lineStart
);

  localparam logic [PIX_W-1:0]  PIX_MAX  = {PIX_W{1'b1}};
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};
  localparam logic [PIX_W-1:0]  PIX_ONE  = PIX_W'(1);

  logic [PIX_W-1:0]  pixNext;
  logic [LINE_W-1:0] lineNext;

  always_comb begin
    pixNext  = pixCount;
    lineNext = lineCount;
    if (ctl.frameStart) begin
      pixNext  = PIX_ONE;
      lineNext = '0;
    end else if (ctl.lineEnd) begin
      pixNext = '0;
      if (lineCount != LINE_MAX) lineNext = lineCount + 1'b1;
    end else if (ctl.pixStep) begin
      if (pixCount != PIX_MAX) pixNext = pixCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pixCount  <= '0;
      lineCount <= '0;
    end else begin
      pixCount  <= pixNext;
      lineCount <= lineNext;
    end
  end

  assign pixAtZero = (pixCount == '0);

  generate
    if (LSTART_EN) begin : g_lstart
      logic lineStartQ;
      always_ff @(posedge clk) begin
        if (rst) lineStartQ <= 1'b0;
        else     lineStartQ <= ctl.lineFirst;
      end
      assign lineStart = lineStartQ;
    end else begin : g_no_lstart
      assign lineStart = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/stream_pos_counter.sv
module stream_pos_counter
  import stream_pos_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int LINE_W    = 6,
  parameter bit LSTART_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tvalid,
  input  logic              tready,
  input  logic              tuser,
  input  logic              tlast,
  output logic [PIX_W-1:0]  pixCount,
  output logic [LINE_W-1:0] lineCount,
  output logic              lineStart
);

  posCtl_t ctl;
  logic    pixAtZero;

  stream_pos_ctrl u_ctrl (
    .tvalid    (tvalid),
    .tready    (tready),
    .tuser     (tuser),
    .tlast     (tlast),
    .pixAtZero (pixAtZero),
    .ctl       (ctl)
  );

  stream_pos_dpath #(
    .PIX_W     (PIX_W),
    .LINE_W    (LINE_W),
    .LSTART_EN (LSTART_EN)
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .pixCount  (pixCount),
    .lineCount (lineCount),
    .pixAtZero (pixAtZero),
    .lineStart (lineStart)
  );

endmodule

// File: rtl/stream_pos_counter_chk.sv
module stream_pos_counter_chk #(
  parameter int PIX_W     = 8,
  parameter int LINE_W    = 6,
  parameter bit LSTART_EN = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              tvalid,
  input logic              tready,
  input logic              tuser,
  input logic              tlast,
  input logic [PIX_W-1:0]  pixCount,
  input logic [LINE_W-1:0] lineCount,
  input logic              lineStart
);

  localparam logic [PIX_W-1:0]  PIX_MAX  = {PIX_W{1'b1}};
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  logic hs;
  assign hs = tvalid && tready;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pixCount == '0 && lineCount == '0 && !lineStart)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !hs |=> ($stable(pixCount) && $stable(lineCount))); // R2

  AST_FRAME_START: assert property (@(posedge clk) disable iff (rst)
    (hs && tuser) |=> (pixCount == PIX_W'(1) && lineCount == '0)); // R3 R6

  AST_LINE_END: assert property (@(posedge clk) disable iff (rst)
    (hs && tlast && !tuser && lineCount != LINE_MAX)
      |=> (pixCount == '0 && lineCount == LINE_W'($past(lineCount) + 1'b1))); // R4

  AST_PIX_STEP: assert property (@(posedge clk) disable iff (rst)
    (hs && !tlast && !tuser && pixCount != PIX_MAX)
      |=> (pixCount == PIX_W'($past(pixCount) + 1'b1))); // R5

  AST_PIX_SAT: assert property (@(posedge clk) disable iff (rst)
    (hs && !tlast && !tuser && pixCount == PIX_MAX) |=> (pixCount == PIX_MAX)); // R7

  AST_LINE_SAT: assert property (@(posedge clk) disable iff (rst)
    (hs && tlast && !tuser && lineCount == LINE_MAX)
      |=> (lineCount == LINE_MAX && pixCount == '0)); // R8

  generate
    if (LSTART_EN) begin : g_chk_lstart
      AST_LSTART_SET: assert property (@(posedge clk) disable iff (rst)
        (hs && (tuser || pixCount == '0)) |=> lineStart); // R9
      AST_LSTART_CLR: assert property (@(posedge clk) disable iff (rst)
        !(hs && (tuser || pixCount == '0)) |=> !lineStart); // R9
    end
  endgenerate

endmodule

bind stream_pos_counter stream_pos_counter_chk #(
  .PIX_W     (PIX_W),
  .LINE_W    (LINE_W),
  .LSTART_EN (LSTART_EN)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tvalid    (tvalid),
  .tready    (tready),
  .tuser     (tuser),
  .tlast     (tlast),
  .pixCount  (pixCount),
  .lineCount (lineCount),
  .lineStart (lineStart)
);

// File: tb/stream_pos_counter_tb_top.sv
module stream_pos_counter_tb_top;

  localparam int PIX_W  = 8;
  localparam int LINE_W = 6;
  localparam int PIX_MAX  = (1 << PIX_W) - 1;
  localparam int LINE_MAX = (1 << LINE_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tvalid = 1'b0, tready = 1'b0, tuser = 1'b0, tlast = 1'b0;
  logic [PIX_W-1:0]  pixCount;
  logic [LINE_W-1:0] lineCount;
  logic lineStart;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  int expPix  = 0;
  int expLine = 0;
  int expSol  = 0;

  always #5 clk = ~clk;

  stream_pos_counter #(.PIX_W(PIX_W), .LINE_W(LINE_W), .LSTART_EN(1'b1)) dut_i (
    .clk(clk), .rst(rst), .tvalid(tvalid), .tready(tready),
    .tuser(tuser), .tlast(tlast),
    .pixCount(pixCount), .lineCount(lineCount), .lineStart(lineStart)
  );

  function automatic int nextPix(int p, bit r, bit hs, bit u, bit l);
    if (r) return 0;
    if (!hs) return p;
    if (u) return 1;
    if (l) return 0;
    return (p == PIX_MAX) ? p : p + 1;
  endfunction

  function automatic int nextLine(int n, bit r, bit hs, bit u, bit l);
    if (r) return 0;
    if (!hs) return n;
    if (u) return 0;
    if (l) return (n == LINE_MAX) ? n : n + 1;
    return n;
  endfunction

  function automatic int nextSol(int p, bit r, bit hs, bit u);
    if (r) return 0;
    return (hs && (u || p == 0)) ? 1 : 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive on falling edge, model at rising edge, compare on next falling edge
  task automatic step(bit r, bit v, bit rd, bit u, bit l);
    string tag;
    bit hs;
    hs = v && rd;
    if (r) tag = "R1";
    else if (!hs) tag = "R2";
    else if (u && l) tag = "R6";
    else if (u) tag = "R3";
    else if (l) tag = (expLine == LINE_MAX) ? "R8" : "R4";
    else tag = (expPix == PIX_MAX) ? "R7" : "R5";
    rst = r; tvalid = v; tready = rd; tuser = u; tlast = l;
    @(posedge clk);
    expSol  = nextSol(expPix, r, hs, u);
    expLine = nextLine(expLine, r, hs, u, l);
    expPix  = nextPix(expPix, r, hs, u, l);
    @(negedge clk);
    check({tag, " pix"},  int'(pixCount),  expPix);
    check({tag, " line"}, int'(lineCount), expLine);
    check("R9 lineStart", int'(lineStart), expSol);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin : stim
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    step(1, 1, 1, 1, 1);             // R1 reset with active beat
    step(0, 0, 0, 0, 0);             // R2 idle after reset
    step(0, 1, 1, 1, 0);             // R3 frame start right away
    step(0, 1, 1, 0, 0);             // R5
    step(0, 1, 0, 0, 0);             // R2 valid without ready
    step(0, 0, 1, 0, 1);             // R2 ready without valid, tlast ignored
    step(0, 1, 1, 0, 0);             // R5
    step(0, 1, 1, 0, 1);             // R4 line end
    step(0, 1, 1, 0, 0);             // R9 first pixel of next line
    step(0, 1, 1, 0, 1);             // R4
    step(0, 1, 1, 1, 1);             // R6 both markers
    for (int i = 0; i < 300; i++) step(0, 1, 1, 0, 0);  // R7 saturate pixels
    for (int i = 0; i < 70; i++)  step(0, 1, 1, 0, 1);  // R8 saturate lines
    step(0, 1, 1, 0, 0);
    step(1, 0, 0, 0, 0);             // R1 mid-run reset
    step(0, 1, 1, 0, 0);             // R9 beat with pixel count 0
    for (int i = 0; i < 4000; i++) begin
      bit v, rd, u, l;
      v  = ($urandom % 4) != 0;
      rd = ($urandom % 4) != 0;
      u  = ($urandom % 32) == 0;
      l  = ($urandom % 16) == 0;
      step(($urandom % 1000) == 0, v, rd, u, l);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule